// File: doc/BRIEF.md
# Four-Instruction Accumulator Processor Core

This block is a very small 8-bit processor that executes a program held in an external asynchronous memory. It presents a 6-bit address, reads instruction and operand bytes from a read-data input, and writes through a separate write-data output with its own drive enable. Read-enable and write-enable strobes are formed from the current state and the clock level, so the memory only sees a strobe during the low half of a clock period.

The core holds a 9-bit accumulator, whose top bit serves as the carry flag, an address register that drives the address bus, and a saved copy of the next sequential instruction address. Each instruction takes a fetch cycle and, except for a taken jump, one execute cycle. The instruction set is bitwise NOR with memory, addition of memory, storing the accumulator to memory, and a jump that is taken only while the carry is clear. A jump that is refused spends its execute cycle clearing the carry, so a carry-driven loop needs no separate flag-clearing instruction.

Top module: `acc4_core`

## Requirements
- R1: While reset is low, and in the first cycle after its release, the address is 0, the write enable and write-data drive are low, and the read enable is high during the clock-low half; the accumulator, including its carry, reads as 0.
- R2: An instruction byte is split into an opcode in bits 7:6 (00 NOR, 01 ADD, 10 STORE, 11 JUMP-IF-CARRY-CLEAR) and a 6-bit memory address in bits 5:0.
- R3: NOR replaces the accumulator's low byte with the inverse of (low byte OR memory byte) and leaves the carry bit unchanged.
- R4: ADD sets the accumulator to the 9-bit sum of its low byte and the memory byte, so bit 8 becomes the carry out.
- R5: STORE drives the accumulator's low byte on the write-data output with the drive enable high during its execute cycle, and raises the write enable only in the clock-low half of that cycle, at the operand address.
- R6: A jump fetched with the carry clear takes no execute cycle: the very next cycle fetches from the jump's target address.
- R7: A jump fetched with the carry set is not taken: its execute cycle has read and write enables low, clears the carry, and the next fetch comes from the address after the jump.
- R8: NOR, ADD, STORE and a refused jump each take exactly two cycles, a fetch at the instruction's address followed by an execute cycle at the operand address.
- R9: The read and write enables are both low while the clock is high, and never high together; the read enable is high in the clock-low half of fetch, NOR and ADD cycles.
- R10: The sequential instruction address wraps from 63 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its level also gates the memory strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 6 | Memory address, driven by the address register |
| mem_rdata | input | 8 | Byte returned by the memory at mem_addr |
| mem_wdata | output | 8 | Byte to be written (accumulator low byte) |
| mem_wdata_oe | output | 1 | High while the core drives mem_wdata (store cycle) |
| mem_oe | output | 1 | Memory read enable, active high |
| mem_we | output | 1 | Memory write enable, active high |

## Verification
The bench sweeps operand pairs through ADD and NOR programs and reads results back through stores, so a sum that lost bit 8, or a NOR that cleared or recomputed the carry, lands as a wrong result byte or a wrong marker byte written only on the refused-jump path. A branch that tested the wrong carry polarity, or a refused jump that left the carry set, would send a halting jump into a loop that never reaches the marker store. A cycle-by-cycle trace of one program checks the address and strobes in both clock halves, catching a store whose write enable leaks into the clock-high half, a taken jump that wastes an execute cycle, and a sequential address that fails to wrap from 63 to 0.

// File: rtl/acc4_pkg.sv
`timescale 1ns/1ps
package acc4_pkg;

  localparam int OP_W = 2;

  typedef enum logic [2:0] {
    ST_FETCH = 3'b000,
    ST_STORE = 3'b001,
    ST_ADD   = 3'b010,
    ST_NOR   = 3'b011,
    ST_CLRC  = 3'b101
  } state_e;

  typedef enum logic [OP_W-1:0] {
    OP_NOR   = 2'b00,
    OP_ADD   = 2'b01,
    OP_STORE = 2'b10,
    OP_JCC   = 2'b11
  } op_e;

  // Execute state is the inverted opcode; a jump maps back onto fetch.
  function automatic state_e exec_state(op_e op);
    return state_e'({1'b0, ~op});
  endfunction

endpackage

// File: rtl/acc4_decode.sv
`timescale 1ns/1ps
module acc4_decode
  import acc4_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic [DATA_W-1:0] instr,
  output op_e               op,
  output logic [ADDR_W-1:0] operand
);

  // Opcode sits in the top bits, address in the bottom bits (R2).
  assign op      = op_e'(instr[DATA_W-1 -: OP_W]);
  assign operand = instr[ADDR_W-1:0];

endmodule

// File: rtl/acc4_ctrl.sv
`timescale 1ns/1ps
module acc4_ctrl
  import acc4_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  op_e    op,
  input  logic   carry,
  output state_e state_q
);

  state_e state_d;

  always_comb begin
    state_d = ST_FETCH;
    if (state_q == ST_FETCH) begin
      if (op == OP_JCC && carry) begin
        state_d = ST_CLRC;
      end else begin
        state_d = exec_state(op);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/acc4_datapath.sv
`timescale 1ns/1ps
module acc4_datapath
  import acc4_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  state_e            state_q,
  input  logic [DATA_W-1:0] rdata,
  input  logic [ADDR_W-1:0] operand,
  output logic [DATA_W:0]   acc_q,
  output logic [ADDR_W-1:0] adreg_q
);

  localparam int ACC_W = DATA_W + 1;
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

  logic [ACC_W-1:0]  acc_d;
  logic              acc_en;
  logic [ADDR_W-1:0] adreg_d;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  logic              pc_en;
  logic [DATA_W-1:0] acc_lo;
  logic              carry;

  assign acc_lo = acc_q[DATA_W-1:0];
  assign carry  = acc_q[DATA_W];

  // Accumulator next value and enable.
  always_comb begin
    acc_d  = acc_q;
    acc_en = 1'b0;
    case (state_q)
      ST_ADD: begin
        acc_en = 1'b1;
        acc_d  = {1'b0, acc_lo} + {1'b0, rdata};
      end
      ST_NOR: begin
        acc_en = 1'b1;
        acc_d  = {carry, ~(acc_lo | rdata)};
      end
      ST_CLRC: begin
        acc_en = 1'b1;
        acc_d  = {1'b0, acc_lo};
      end
      default: begin
        acc_en = 1'b0;
      end
    endcase
  end

  // Address register: operand after fetch, saved counter otherwise.
  always_comb begin
    pc_en   = (state_q == ST_FETCH);
    pc_d    = adreg_q + ADDR_ONE;
    adreg_d = (state_q == ST_FETCH) ? operand : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adreg_q <= '0;
    end else begin
      adreg_q <= adreg_d;
    end
  end

endmodule

// File: rtl/acc4_strobe.sv
`timescale 1ns/1ps
module acc4_strobe
  import acc4_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  state_e            state_q,
  input  logic [DATA_W-1:0] acc_lo,
  output logic              mem_oe,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wdata_oe
);

  logic is_store;
  logic no_read;

  always_comb begin
    is_store     = (state_q == ST_STORE);
    no_read      = is_store || (state_q == ST_CLRC);
    mem_oe       = ~clk & ~no_read;
    mem_we       = ~clk & is_store;
    mem_wdata_oe = is_store;
    mem_wdata    = acc_lo;
  end

endmodule

// File: rtl/acc4_core.sv
`timescale 1ns/1ps
module acc4_core
  import acc4_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wdata_oe,
  output logic              mem_oe,
  output logic              mem_we
);

  op_e               op;
  logic [ADDR_W-1:0] operand;
  state_e            state_q;
  logic [DATA_W:0]   acc_q;
  logic [ADDR_W-1:0] adreg_q;

  acc4_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .instr   (mem_rdata),
    .op      (op),
    .operand (operand)
  );

  acc4_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .carry   (acc_q[DATA_W]),
    .state_q (state_q)
  );

  acc4_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_q (state_q),
    .rdata   (mem_rdata),
    .operand (operand),
    .acc_q   (acc_q),
    .adreg_q (adreg_q)
  );

  acc4_strobe #(.DATA_W(DATA_W)) u_stb (
    .clk          (clk),
    .state_q      (state_q),
    .acc_lo       (acc_q[DATA_W-1:0]),
    .mem_oe       (mem_oe),
    .mem_we       (mem_we),
    .mem_wdata    (mem_wdata),
    .mem_wdata_oe (mem_wdata_oe)
  );

  assign mem_addr = adreg_q;

endmodule

// File: rtl/acc4_core_chk.sv
`timescale 1ns/1ps
module acc4_core_chk
  import acc4_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input state_e            state_q,
  input logic [DATA_W:0]   acc_q,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_wdata_oe,
  input logic              mem_oe,
  input logic              mem_we
);

  localparam logic [ADDR_W-1:0] A_ONE = 1;

  // Sampling at the rising edge observes clock-low values.
  p_nor_keeps_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_NOR |=> (acc_q[DATA_W] == $past(acc_q[DATA_W])) &&
      (acc_q[DATA_W-1:0] == ~($past(acc_q[DATA_W-1:0]) | $past(mem_rdata))));

  p_add_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_ADD |=> acc_q == ({1'b0, $past(acc_q[DATA_W-1:0])} + {1'b0, $past(mem_rdata)}));

  p_store_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (state_q == ST_STORE) && mem_wdata_oe && (mem_wdata == acc_q[DATA_W-1:0]));

  p_jump_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) && (mem_rdata[DATA_W-1 -: OP_W] == 2'b11) && !acc_q[DATA_W]
    |=> (state_q == ST_FETCH) && (mem_addr == $past(mem_rdata[ADDR_W-1:0])));

  p_refused_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_CLRC |=> !acc_q[DATA_W]);

  p_exec_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != ST_FETCH |=> state_q == ST_FETCH);

  p_seq_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_FETCH) && (state_q != ST_FETCH)
    |=> mem_addr == $past(mem_addr, 2) + A_ONE);

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_oe && mem_we));

  p_read_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH || state_q == ST_ADD || state_q == ST_NOR) |-> mem_oe);

  // Sampling at the falling edge observes clock-high values.
  p_quiet_high_r9: assert property (@(negedge clk) disable iff (!rst_n)
    !mem_oe && !mem_we);

endmodule

bind acc4_core acc4_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .state_q      (state_q),
  .acc_q        (acc_q),
  .mem_addr     (mem_addr),
  .mem_rdata    (mem_rdata),
  .mem_wdata    (mem_wdata),
  .mem_wdata_oe (mem_wdata_oe),
  .mem_oe       (mem_oe),
  .mem_we       (mem_we)
);

// File: tb/sim_acc4_core.sv
`timescale 1ns/1ps
module sim_acc4_core;

  localparam int DW = 8;
  localparam int AW = 6;
  localparam int WD_CYCLES = 150000;

  localparam logic [1:0] K_NOR = 2'b00;
  localparam logic [1:0] K_ADD = 2'b01;
  localparam logic [1:0] K_STA = 2'b10;
  localparam logic [1:0] K_JCC = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] mem_wdata;
  logic          mem_wdata_oe;
  logic          mem_oe;
  logic          mem_we;

  logic [DW-1:0] mem [64];

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  acc4_core #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_addr     (mem_addr),
    .mem_rdata    (mem_rdata),
    .mem_wdata    (mem_wdata),
    .mem_wdata_oe (mem_wdata_oe),
    .mem_oe       (mem_oe),
    .mem_we       (mem_we)
  );

  // Asynchronous memory model.
  assign mem_rdata = mem[mem_addr];

  always @(negedge clk) begin
    #1.5;
    if (mem_we) mem[mem_addr] = mem_wdata_oe ? mem_wdata : 8'h5A;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ins(input logic [1:0] op, input int adr);
    logic [5:0] a6;
    a6 = adr[5:0];
    return {op, a6};
  endfunction

  task automatic clear_mem;
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
  endtask

  task automatic hold_reset;
    @(negedge clk);
    #0.5;
    rst_n = 1'b0;
  endtask

  task automatic release_run(input int n);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
    #2;
  endtask

  // Shared tail: marker 0xC1 is stored at 52 only when the jump is refused.
  task automatic load_tail(input int at);
    mem[at]   = ins(K_JCC, at + 4);
    mem[at+1] = ins(K_NOR, 60);
    mem[at+2] = ins(K_ADD, 59);
    mem[at+3] = ins(K_STA, 52);
    mem[at+4] = ins(K_JCC, at + 4);
    mem[59]   = 8'hC1;
    mem[60]   = 8'hFF;
  endtask

  localparam logic [5:0] EA [14] = '{6'd0, 6'd5, 6'd40, 6'd6, 6'd41, 6'd7, 6'd41,
                                     6'd8, 6'd0, 6'd9, 6'd63, 6'd42, 6'd0, 6'd5};
  localparam logic [2:0] ES [14] = '{3'b100, 3'b100, 3'b011, 3'b100, 3'b100, 3'b100, 3'b100,
                                     3'b100, 3'b000, 3'b100, 3'b100, 3'b011, 3'b100, 3'b100};
  localparam logic [7:0] EW [14] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                                     8'h00, 8'h00, 8'h00, 8'h00, 8'h20, 8'h00, 8'h00};

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", WD_CYCLES, WD_CYCLES);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int s;
    int nv;
    // ADD sweep: R2, R4, R6, R7
    for (int a = 0; a < 256; a += 15) begin
      for (int b = 0; b < 256; b += 15) begin
        hold_reset;
        clear_mem;
        s = a + b;
        mem[0]  = ins(K_NOR, 60);
        mem[1]  = ins(K_ADD, 61);
        mem[2]  = ins(K_ADD, 62);
        mem[3]  = ins(K_STA, 50);
        load_tail(4);
        mem[61] = a[7:0];
        mem[62] = b[7:0];
        mem[50] = ~s[7:0];
        release_run(24);
        chk($sformatf("R2/R4 sum a=%0d b=%0d", a, b), {24'd0, mem[50]}, {24'd0, s[7:0]});
        chk($sformatf("R6/R7 carry branch a=%0d b=%0d", a, b), {24'd0, mem[52]},
            (s > 255) ? 32'hC1 : 32'h00);
      end
    end

    // NOR sweep with carry preset: R3
    for (int a = 0; a < 256; a += 17) begin
      for (int b = 0; b < 256; b += 17) begin
        hold_reset;
        clear_mem;
        nv = ~(a | b) & 255;
        mem[0]  = ins(K_ADD, 57);
        mem[1]  = ins(K_ADD, 57);
        mem[2]  = ins(K_NOR, 60);
        mem[3]  = ins(K_NOR, 61);
        mem[4]  = ins(K_NOR, 62);
        mem[5]  = ins(K_STA, 50);
        load_tail(6);
        mem[57] = 8'hFF;
        mem[61] = ~a[7:0];
        mem[62] = b[7:0];
        mem[50] = ~nv[7:0];
        release_run(28);
        chk($sformatf("R3 nor a=%0d b=%0d", a, b), {24'd0, mem[50]}, nv);
        chk($sformatf("R3 carry kept a=%0d b=%0d", a, b), {24'd0, mem[52]}, 32'hC1);
      end
    end

    // Cycle trace: R1, R5, R6, R7, R8, R9, R10
    hold_reset;
    #0.5;
    chk("R1 reset addr", {26'd0, mem_addr}, 32'd0);
    chk("R1 reset strobes", {29'd0, mem_oe, mem_we, mem_wdata_oe}, 32'b100);
    clear_mem;
    mem[0]  = ins(K_JCC, 5);
    mem[5]  = ins(K_STA, 40);
    mem[6]  = ins(K_ADD, 41);
    mem[7]  = ins(K_ADD, 41);
    mem[8]  = ins(K_JCC, 0);
    mem[9]  = ins(K_JCC, 63);
    mem[63] = ins(K_STA, 42);
    mem[40] = 8'hAA;
    mem[41] = 8'h90;
    mem[42] = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 first cycle addr", {26'd0, mem_addr}, {26'd0, EA[0]});
    chk("R1 first cycle strobes", {29'd0, mem_oe, mem_we, mem_wdata_oe}, {29'd0, ES[0]});
    for (int k = 1; k < 14; k++) begin
      @(posedge clk);
      #1;
      chk($sformatf("R9 high phase quiet cycle %0d", k), {30'd0, mem_oe, mem_we}, 32'd0);
      @(negedge clk);
      #1;
      chk($sformatf("R6/R7/R8/R10 addr cycle %0d", k), {26'd0, mem_addr}, {26'd0, EA[k]});
      chk($sformatf("R5/R7/R9 strobes cycle %0d", k), {29'd0, mem_oe, mem_we, mem_wdata_oe},
          {29'd0, ES[k]});
      if (ES[k][0]) chk($sformatf("R5 wdata cycle %0d", k), {24'd0, mem_wdata}, {24'd0, EW[k]});
    end
    chk("R1/R5 reset acc stored", {24'd0, mem[40]}, 32'h00);
    chk("R5 sum stored after wrap", {24'd0, mem[42]}, 32'h20);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule